// File: doc/BRIEF.md
# Programmable-Length Split-Mode Delay Line

This block delays a byte stream by a run-time selectable number of clock stages, from 3 up to 18. A 4-bit length code chooses the delay, and the delay in clocks is the code plus three. The byte travels as two independent 4-bit lanes. Each lane has its own shift chain and its own 1-of-16 tap selector. The data values pass through unaltered; only their timing changes.

A mode bit picks between two arrangements. In uniform mode both lanes take the programmed delay, so the whole byte is delayed as one word. In split mode the upper lane (bits 7..4) is pinned at the full 18-stage delay, while the lower lane (bits 3..0) keeps following the length code. The length code and the mode bit are both registered before they reach the tap selectors. A synchronous active-high reset clears only these two control registers, to code 0 in uniform mode. The data stages have no reset.

Top module: `split_delay_line`

## Requirements
- R1: In uniform mode, a value sampled on `din` at one rising edge appears on `dout` after the edge that is (code + 3) edges later, counting the sampling edge as the first. Code 0 gives 3 stages and code 15 gives 18 stages.
- R2: Every one of the 256 byte values reaches `dout` bit for bit unchanged. Bits 3..0 form the lower lane and bits 7..4 form the upper lane.
- R3: When the mode bit is 1 (split), bits 7..4 of `dout` are delayed by 18 stages whatever the code is, and bits 3..0 are delayed by (code + 3) stages.
- R4: When the mode bit is 0 (uniform), bits 7..4 have exactly the same delay as bits 3..0.
- R5: The length code is captured at a rising edge and first selects the tap at the next rising edge. A code changed every cycle is therefore applied with one cycle of latency.
- R6: The mode bit is captured the same way as the length code, with the same one-cycle latency, including when it toggles every cycle.
- R7: While `rst` is high at an edge, the captured controls become code 0 in uniform mode, whatever `len_sel` and `split_en` are. The data chain keeps shifting, so the output shows a 3-stage delay on both lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; every register acts on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the control registers only |
| din | input | 8 | Data byte; bits 3..0 are the lower lane, bits 7..4 are the upper lane |
| len_sel | input | 4 | Length code; delay is code + 3 stages |
| split_en | input | 1 | 1 = split mode (upper lane fixed at 18), 0 = uniform mode |
| dout | output | 8 | Delayed data byte |

## Verification
The hardest situation to reach from the ports is a tap selection that differs from the one implied by the current inputs. This happens in the cycle after a control change, and throughout reset while the inputs ask for the longest delay in split mode.

The bench holds `len_sel` at 15 and `split_en` at 1 during a long reset, so the register-cleared controls alone decide the expected 3-stage output. It then changes the length code every cycle, and later toggles the mode every cycle as well. Every output is compared against the control value recorded one edge earlier, so a selector that reads the live inputs, or that lags by two cycles, gives a mismatch.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

    // Width of the length code and the number of selectable taps.
    localparam int CODE_W     = 4;
    localparam int TAPS       = 1 << CODE_W;
    // Stages in front of the first tap: the input register and one more.
    localparam int PRE_TAP    = 2;
    // The output register adds the last stage of every path.
    localparam int MIN_STAGES = PRE_TAP + 1;
    localparam int MAX_STAGES = MIN_STAGES + TAPS - 1;
    // Register stages per lane, not counting the output register.
    localparam int CHAIN_LEN  = PRE_TAP + TAPS - 1;

    typedef logic [CODE_W-1:0] len_code_t;

    typedef enum logic {
        MODE_UNIFORM = 1'b0,
        MODE_SPLIT   = 1'b1
    } lane_mode_t;

    typedef struct packed {
        lane_mode_t mode;
        len_code_t  code;
    } ctrl_t;

    // The tap code a lane uses: in split mode the top lane takes the longest tap.
    function automatic len_code_t lane_code(ctrl_t c, int lane, int lanes);
        if (c.mode == MODE_SPLIT && lane == lanes - 1)
            return '1;
        return c.code;
    endfunction

endpackage

// File: rtl/sdl_ctrl_regs.sv
module sdl_ctrl_regs
    import sdl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  len_code_t len_in,
    input  logic      split_in,
    output ctrl_t     ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '{mode: MODE_UNIFORM, code: '0};
        end else begin
            ctrl_q <= '{mode: lane_mode_t'(split_in), code: len_in};
        end
    end

endmodule

// File: rtl/sdl_tap_select.sv
module sdl_tap_select
    import sdl_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [TAPS-1:0][W-1:0] taps,
    input  len_code_t              code,
    output logic [W-1:0]           pick
);

    logic [TAPS-1:0] hit;

    // The code is decoded to a one-hot vector; that vector gates an AND-OR tree.
    always_comb begin
        for (int j = 0; j < TAPS; j++) begin
            hit[j] = (code == len_code_t'(j));
        end
    end

    always_comb begin
        pick = '0;
        for (int j = 0; j < TAPS; j++) begin
            pick = pick | (taps[j] & {W{hit[j]}});
        end
    end

endmodule

// File: rtl/sdl_delay_lane.sv
module sdl_delay_lane
    import sdl_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    input  len_code_t    code,
    output logic [W-1:0] q
);

    // stage[1] is the input register; stage[k] holds the sample taken k-1 edges ago.
    logic [CHAIN_LEN:1][W-1:0] stage;
    logic [TAPS-1:0][W-1:0]    taps;
    logic [W-1:0]              picked;

    always_ff @(posedge clk) begin
        stage <= {stage[CHAIN_LEN-1:1], d};
    end

    // Tap j reads stage j + PRE_TAP. With the output register this gives j + MIN_STAGES.
    always_comb begin
        for (int j = 0; j < TAPS; j++) begin
            taps[j] = stage[j + PRE_TAP];
        end
    end

    sdl_tap_select #(.W(W)) u_sel (
        .taps (taps),
        .code (code),
        .pick (picked)
    );

    always_ff @(posedge clk) begin
        q <= picked;
    end

endmodule

// File: rtl/split_delay_line.sv
module split_delay_line
    import sdl_pkg::*;
#(
    parameter  int LANE_W = 4,
    parameter  int LANES  = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] len_sel,
    input  logic              split_en,
    output logic [DATA_W-1:0] dout
);

    localparam int UP_LO = (LANES - 1) * LANE_W;

    ctrl_t ctrl_q;

    sdl_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .len_in   (len_sel),
        .split_in (split_en),
        .ctrl_q   (ctrl_q)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        len_code_t code_i;
        assign code_i = lane_code(ctrl_q, i, LANES);

        sdl_delay_lane #(.W(LANE_W)) u_lane (
            .clk  (clk),
            .d    (din[i*LANE_W +: LANE_W]),
            .code (code_i),
            .q    (dout[i*LANE_W +: LANE_W])
        );
    end

    // Counts edges since reset so that the $past windows below only look at
    // history that is known. It saturates once the deepest window is covered.
    localparam int AGE_MAX = MAX_STAGES + 1;
    localparam int AGE_W   = $clog2(AGE_MAX + 1);
    localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_MAX);

    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            age <= '0;
        end else if (age != AGE_TOP) begin
            age <= age + 1'b1;
        end
    end

    AST_MIN_DELAY: assert property (@(posedge clk) disable iff (rst)
        (age == AGE_TOP && $past(ctrl_q.code) == '0 && $past(ctrl_q.mode) == MODE_UNIFORM)
        |-> dout == $past(din, MIN_STAGES))
        else $error("shortest uniform delay broken"); // R1

    AST_MAX_DELAY: assert property (@(posedge clk) disable iff (rst)
        (age == AGE_TOP && $past(ctrl_q.code) == '1)
        |-> dout == $past(din, MAX_STAGES))
        else $error("longest delay broken"); // R1

    AST_SPLIT_UPPER: assert property (@(posedge clk) disable iff (rst)
        (age == AGE_TOP && $past(ctrl_q.mode) == MODE_SPLIT)
        |-> dout[DATA_W-1:UP_LO] == $past(din[DATA_W-1:UP_LO], MAX_STAGES))
        else $error("upper lane not pinned in split mode"); // R3

    AST_SPLIT_LOWER_MIN: assert property (@(posedge clk) disable iff (rst)
        (age == AGE_TOP && $past(ctrl_q.mode) == MODE_SPLIT && $past(ctrl_q.code) == '0)
        |-> dout[LANE_W-1:0] == $past(din[LANE_W-1:0], MIN_STAGES))
        else $error("lower lane ignores code in split mode"); // R3

endmodule

// File: tb/tb_split_delay_line.sv
module tb_split_delay_line;
    import sdl_pkg::*;

    localparam int DW    = 8;
    localparam int DEPTH = 4096;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DW-1:0]     din = '0;
    logic [CODE_W-1:0] len_sel = '0;
    logic              split_en = 1'b0;
    logic [DW-1:0]     dout;

    always #4 clk = ~clk;

    split_delay_line dut (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .len_sel  (len_sel),
        .split_en (split_en),
        .dout     (dout)
    );

    int    checks = 0;
    int    errors = 0;
    int    n      = -1;
    bit    chk_on = 1'b0;
    string tag_lo = "R7";
    string tag_hi = "R7";

    // History of what the design captured at each edge.
    logic [DW-1:0] h_d    [DEPTH];
    int            h_len  [DEPTH];
    bit            h_mode [DEPTH];

    task automatic check(input string tag, input string lane,
                         input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s lane=%s edge=%0d got=%h exp=%h", tag, lane, n, got, exp);
        end
    endtask

    // Drives one cycle. After the edge the expected output is built from the
    // controls captured one edge earlier: delay = code + 3, or 18 for the
    // upper lane in split mode.
    task automatic cyc(input logic [7:0] d, input int len, input bit md, input bit r);
        din      = d;
        len_sel  = len[3:0];
        split_en = md;
        rst      = r;
        @(posedge clk);
        n++;
        h_d[n]    = d;
        h_len[n]  = r ? 0 : len;
        h_mode[n] = r ? 1'b0 : md;
        #1;
        if (chk_on && n >= 1) begin
            int dlo;
            int dhi;
            dlo = h_len[n-1] + 3;
            dhi = h_mode[n-1] ? 18 : dlo;
            if (n - dlo + 1 >= 0) check(tag_lo, "lo", dout[3:0], h_d[n-dlo+1][3:0]);
            if (n - dhi + 1 >= 0) check(tag_hi, "hi", dout[7:4], h_d[n-dhi+1][7:4]);
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk_on = 1'b1;

        // R7: reset forces code 0 in uniform mode while the inputs ask for 18 in split mode.
        tag_lo = "R7"; tag_hi = "R7";
        repeat (24) cyc(8'($urandom), 15, 1'b1, 1'b1);

        // R1 / R4: uniform mode, every code held long enough to fill the chain.
        tag_lo = "R1"; tag_hi = "R4";
        for (int c = 0; c < 16; c++) begin
            repeat (22) cyc(8'($urandom), c, 1'b0, 1'b0);
        end

        // R3: split mode, every code.
        tag_lo = "R3"; tag_hi = "R3";
        for (int c = 0; c < 16; c++) begin
            repeat (22) cyc(8'($urandom), c, 1'b1, 1'b0);
        end

        // R2: every byte value passes intact.
        tag_lo = "R2"; tag_hi = "R2";
        for (int v = 0; v < 256; v++) begin
            cyc(8'(v), 7, 1'b0, 1'b0);
        end

        // R5: the length code changes every cycle, first in uniform and then in split mode.
        tag_lo = "R5"; tag_hi = "R5";
        for (int k = 0; k < 400; k++) begin
            cyc(8'($urandom), int'($urandom % 16), (k >= 200), 1'b0);
        end

        // R6: the mode toggles at random every cycle, together with random codes.
        tag_lo = "R6"; tag_hi = "R6";
        for (int k = 0; k < 300; k++) begin
            cyc(8'($urandom), int'($urandom % 16), 1'($urandom), 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule